// File: doc/BRIEF.md
# Four-Slot Daisy-Chain Interrupt Prioritizer

This block merges the interrupt requests of four counter channels into a single interrupt line. Its four channels take four adjacent positions in a chained interrupt scheme. An enable arrives from the device upstream and an enable leaves toward the device downstream. Channel 0 ranks highest and channel 3 lowest. Each channel keeps a pending flag, which an enabled request pulse sets, and an in-service flag. The interrupt line is asserted only when the upstream enable is high and no channel of higher rank is pending or under service.

The processor acknowledges by asserting its machine-cycle-one and I/O-request strobes together. While both are held, the block drives the winning channel's vector and a drive enable for the data bus. The vector is a programmed base in bits 7..3, the two-bit channel number in bits 2..1, and a zero in bit 0. At the first cycle of the acknowledge, the winner moves from pending to in-service. A return-from-interrupt pulse clears the highest-ranked in-service channel, which lets channels of lower rank request again.

Top module: `irq_chain4`

## Requirements
- R1: After reset, no channel is pending or in service and the vector base is zero. During and after reset, int_o is 0, vec_oe_o is 0 and ieo_o equals iei_i.
- R2: A request pulse on an enabled channel sets its pending flag at the next clock edge. int_o then reads 1 in the following cycle if iei_i is high and no channel of higher rank is pending or in service.
- R3: A request on a channel whose enable is low is ignored. While a channel's enable is low, its pending flag is cleared at each clock edge.
- R4: When several channels can request, exactly one wins: the one with the lowest index. An acknowledge returns that channel's vector.
- R5: While iei_i is low, int_o and ieo_o are both 0. Pending flags are kept, and int_o returns once iei_i goes high again.
- R6: ieo_o is 1 exactly when iei_i is 1 and no channel is pending or in service.
- R7: The vector is {base[7:3], channel[1:0], 1'b0}. A write with wr_en_i high loads base from wr_data_i only when wr_data_i[0] is 0. A write with wr_data_i[0] equal to 1 leaves the base unchanged.
- R8: The acknowledge is m1_i and iorq_i both high. While it is held, vec_oe_o is 1 if a channel was requesting in its first cycle, and vec_o stays constant for the whole acknowledge. At the first edge of the acknowledge, the winner moves from pending to in-service, and int_o falls.
- R9: A channel in service blocks itself and every channel of lower rank. A channel of higher rank can still interrupt, so service nests.
- R10: A reti_i pulse clears only the highest-ranked in-service channel at the next edge. Lower channels then request again.
- R11: Several requests on one channel before its acknowledge merge into one pending flag. One acknowledge followed by one return leaves nothing requesting.
- R12: An acknowledge while no channel is requesting keeps vec_oe_o at 0 and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 4 | Per-channel request pulses, bit n for channel n |
| ien_i | input | 4 | Per-channel interrupt enable |
| iei_i | input | 1 | Chain enable from the upstream device |
| m1_i | input | 1 | Machine-cycle-one strobe, active high |
| iorq_i | input | 1 | I/O-request strobe, active high |
| reti_i | input | 1 | Return-from-interrupt pulse |
| wr_en_i | input | 1 | Vector base write strobe |
| wr_data_i | input | 8 | Write data; loads the base when bit 0 is 0 |
| int_o | output | 1 | Interrupt request to the processor |
| ieo_o | output | 1 | Chain enable to the downstream device |
| vec_oe_o | output | 1 | Data-bus drive enable for the vector |
| vec_o | output | 8 | Interrupt vector |

## Verification
The bench builds the block with its defaults: four channels and an 8-bit vector. With these values every slot of the chain is present, the two-bit channel field covers all four codes, and service can nest through the full depth, from channel 0 down to channel 3. A table walk covers requests, disabled channels and changes of the upstream enable. Directed sequences then cover nested acknowledges and returns, merged requests, an acknowledge with nothing requesting, a held multi-cycle acknowledge, and a reset taken mid-operation.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_HOLD = 1'b1
  } ack_phase_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/irq_slot.sv
module irq_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ien_i,
  input  logic take_i,
  input  logic done_i,
  output logic pend_o,
  output logic insvc_o
);

  logic pend_q, pend_d;
  logic svc_q, svc_d;
  logic upd;

  always_comb begin
    pend_d = ien_i & ((pend_q & ~take_i) | req_i);
    svc_d  = (svc_q & ~done_i) | take_i;
    upd    = req_i | take_i | done_i | (pend_q & ~ien_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else if (upd) begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
    end
  end

  assign pend_o  = pend_q;
  assign insvc_o = svc_q;

endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            iei_i,
  input  logic [NCH-1:0]  pend_i,
  input  logic [NCH-1:0]  insvc_i,
  output logic [NCH-1:0]  grant_o,
  output logic [NCH-1:0]  top_svc_o,
  output logic            win_v_o,
  output logic [CH_W-1:0] win_id_o,
  output logic            ieo_o
);

  logic en;
  logic seen;

  always_comb begin
    en        = iei_i;
    seen      = 1'b0;
    grant_o   = '0;
    top_svc_o = '0;
    win_v_o   = 1'b0;
    win_id_o  = '0;
    for (int i = 0; i < NCH; i++) begin
      grant_o[i] = en & pend_i[i] & ~insvc_i[i];
      if (grant_o[i]) begin
        win_v_o  = 1'b1;
        win_id_o = CH_W'(i);
      end
      top_svc_o[i] = insvc_i[i] & ~seen;
      seen         = seen | insvc_i[i];
      en           = en & ~pend_i[i] & ~insvc_i[i];
    end
    ieo_o = en;
  end

endmodule

// File: rtl/irq_vec.sv
module irq_vec
  import irq_chain_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [VEC_W-1:0] wr_data_i,
  input  logic             ack_i,
  input  logic             win_v_i,
  input  logic [CH_W-1:0]  win_id_i,
  output logic             take_o,
  output logic             vec_oe_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam logic [VEC_W-1:0] LOW_MASK = VEC_W'((1 << (CH_W + 1)) - 1);

  ack_phase_t      phase_q, phase_d;
  logic            held_v_q, held_v_d;
  logic [CH_W-1:0] held_id_q, held_id_d;
  logic [VEC_W-1:0] base_q, base_d;
  logic            base_en;
  logic            start;
  logic [CH_W-1:0] cur_id;

  always_comb begin
    start     = ack_i & (phase_q == ACK_IDLE);
    phase_d   = ack_i ? ACK_HOLD : ACK_IDLE;
    held_v_d  = held_v_q;
    held_id_d = held_id_q;
    if (start) begin
      held_v_d  = win_v_i;
      held_id_d = win_id_i;
    end
    base_en = wr_en_i & ~wr_data_i[0];
    base_d  = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= ACK_IDLE;
      held_v_q  <= 1'b0;
      held_id_q <= '0;
    end else begin
      phase_q   <= phase_d;
      held_v_q  <= held_v_d;
      held_id_q <= held_id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_comb begin
    cur_id   = start ? win_id_i : held_id_q;
    take_o   = start & win_v_i;
    vec_oe_o = ack_i & (start ? win_v_i : held_v_q);
    vec_o    = (base_q & ~LOW_MASK) | (VEC_W'(cur_id) << 1);
  end

endmodule

// File: rtl/irq_chain4.sv
module irq_chain4 #(
  parameter int NCH   = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_i,
  input  logic [NCH-1:0]   ien_i,
  input  logic             iei_i,
  input  logic             m1_i,
  input  logic             iorq_i,
  input  logic             reti_i,
  input  logic             wr_en_i,
  input  logic [VEC_W-1:0] wr_data_i,
  output logic             int_o,
  output logic             ieo_o,
  output logic             vec_oe_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            rst_n_s;
  logic [NCH-1:0]  pend_w;
  logic [NCH-1:0]  insvc_w;
  logic [NCH-1:0]  grant_w;
  logic [NCH-1:0]  top_svc_w;
  logic [NCH-1:0]  take_w;
  logic [NCH-1:0]  done_w;
  logic            win_v_w;
  logic [CH_W-1:0] win_id_w;
  logic            take_any;
  logic            ack_w;

  assign ack_w = m1_i & iorq_i;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irq_prio_chain #(.NCH(NCH), .CH_W(CH_W)) u_chain (
    .iei_i     (iei_i),
    .pend_i    (pend_w),
    .insvc_i   (insvc_w),
    .grant_o   (grant_w),
    .top_svc_o (top_svc_w),
    .win_v_o   (win_v_w),
    .win_id_o  (win_id_w),
    .ieo_o     (ieo_o)
  );

  irq_vec #(.VEC_W(VEC_W), .CH_W(CH_W)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ack_i     (ack_w),
    .win_v_i   (win_v_w),
    .win_id_i  (win_id_w),
    .take_o    (take_any),
    .vec_oe_o  (vec_oe_o),
    .vec_o     (vec_o)
  );

  assign take_w = grant_w & {NCH{take_any}};
  assign done_w = top_svc_w & {NCH{reti_i}};

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    irq_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .req_i   (req_i[g]),
      .ien_i   (ien_i[g]),
      .take_i  (take_w[g]),
      .done_i  (done_w[g]),
      .pend_o  (pend_w[g]),
      .insvc_o (insvc_w[g])
    );
  end

  assign int_o = win_v_w;

endmodule

// File: rtl/irq_chain4_chk.sv
module irq_chain4_chk #(
  parameter int NCH   = 4,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iei_i,
  input logic             m1_i,
  input logic             iorq_i,
  input logic             reti_i,
  input logic             int_o,
  input logic             ieo_o,
  input logic             vec_oe_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [NCH-1:0]   grant,
  input logic [NCH-1:0]   insvc
);

  assert_int_needs_iei_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !iei_i |-> (!int_o && !ieo_o));

  assert_int_blocks_ieo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !ieo_o);

  assert_oe_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe_o |-> (m1_i && iorq_i));

  assert_vec_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_o));

  assert_vec_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe_o |-> (vec_o[0] == 1'b0));

  assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_reti_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && (insvc != '0) && !(m1_i && iorq_i)) |=>
      ($countones(insvc) == $countones($past(insvc)) - 1));

endmodule

bind irq_chain4 irq_chain4_chk #(.NCH(NCH), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iei_i    (iei_i),
  .m1_i     (m1_i),
  .iorq_i   (iorq_i),
  .reti_i   (reti_i),
  .int_o    (int_o),
  .ieo_o    (ieo_o),
  .vec_oe_o (vec_oe_o),
  .vec_o    (vec_o),
  .grant    (grant_w),
  .insvc    (insvc_w)
);

// File: tb/tb_irq_chain4.sv
module tb_irq_chain4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req, ien;
  logic       iei, m1, iorq, reti, wr_en;
  logic [7:0] wr_data;
  logic       int_o, ieo_o, vec_oe;
  logic [7:0] vec;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_chain4 dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ien_i(ien), .iei_i(iei),
    .m1_i(m1), .iorq_i(iorq), .reti_i(reti), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .int_o(int_o), .ieo_o(ieo_o),
    .vec_oe_o(vec_oe), .vec_o(vec)
  );

  // row: {req[3:0], ien[3:0], iei, exp_int, exp_ieo}
  localparam logic [10:0] TBL [8] = '{
    {4'b0000, 4'b1111, 1'b1, 1'b0, 1'b1},  // R6 idle chain
    {4'b0100, 4'b1111, 1'b1, 1'b1, 1'b0},  // R2 ch2 request
    {4'b0000, 4'b1111, 1'b0, 1'b0, 1'b0},  // R5 upstream low
    {4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0},  // R5 pending kept
    {4'b0000, 4'b1011, 1'b1, 1'b0, 1'b1},  // R3 disable clears
    {4'b0100, 4'b1011, 1'b1, 1'b0, 1'b1},  // R3 disabled ignored
    {4'b1000, 4'b1111, 1'b1, 1'b1, 1'b0},  // R2 ch3 request
    {4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1}   // R3 all disabled
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pulse_req(input logic [3:0] r);
    req = r;
    @(negedge clk);
    req = 4'b0000;
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic do_ack(input string tag, input logic exp_oe, input logic [7:0] exp_vec, input int cyc);
    m1 = 1'b1; iorq = 1'b1;
    #1;
    check({tag, " oe"}, 32'(vec_oe), 32'(exp_oe));
    if (exp_oe) check({tag, " vec"}, 32'(vec), 32'(exp_vec));
    for (int k = 1; k < cyc; k++) begin
      @(negedge clk);
      check({tag, " oe held"}, 32'(vec_oe), 32'(exp_oe));
      if (exp_oe) check({tag, " vec held"}, 32'(vec), 32'(exp_vec));
    end
    @(negedge clk);
    m1 = 1'b0; iorq = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; req = '0; ien = 4'b1111; iei = 1'b1;
    m1 = 1'b0; iorq = 1'b0; reti = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset int", 32'(int_o), 0);
    check("R1 reset ieo", 32'(ieo_o), 1);
    check("R1 reset oe", 32'(vec_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 base load, then an ignored write with bit 0 set
    wr_en = 1'b1; wr_data = 8'hA8; @(negedge clk);
    wr_data = 8'h51; @(negedge clk);
    wr_en = 1'b0;

    for (int r = 0; r < 8; r++) begin
      req = TBL[r][10:7]; ien = TBL[r][6:3]; iei = TBL[r][2];
      @(negedge clk);
      check($sformatf("R2/R3/R5/R6 row%0d int", r), 32'(int_o), 32'(TBL[r][1]));
      check($sformatf("R2/R3/R5/R6 row%0d ieo", r), 32'(ieo_o), 32'(TBL[r][0]));
    end
    req = '0; ien = 4'b1111; iei = 1'b1;
    @(negedge clk);

    // R4 priority among ch1..ch3, R7 vector, R8 held acknowledge
    pulse_req(4'b1110);
    check("R2 int multi", 32'(int_o), 1);
    do_ack("R4 R8 ack ch1", 1'b1, 8'hAA, 3);
    @(negedge clk);
    check("R9 lower blocked int", 32'(int_o), 0);
    check("R6 ieo busy", 32'(ieo_o), 0);

    // R9 nesting by ch0
    pulse_req(4'b0001);
    check("R9 higher nests", 32'(int_o), 1);
    do_ack("R9 ack ch0", 1'b1, 8'hA8, 1);
    @(negedge clk);
    check("R8 int falls", 32'(int_o), 0);

    // R10 returns unwind in rank order
    pulse_reti();
    check("R10 ch1 still served", 32'(int_o), 0);
    pulse_reti();
    check("R10 ch2 resumes", 32'(int_o), 1);
    do_ack("R10 ack ch2", 1'b1, 8'hAC, 1);
    pulse_reti();
    check("R10 ch3 resumes", 32'(int_o), 1);
    do_ack("R10 ack ch3", 1'b1, 8'hAE, 1);
    pulse_reti();
    check("R10 all clear int", 32'(int_o), 0);
    check("R6 all clear ieo", 32'(ieo_o), 1);

    // R12 acknowledge with nothing requesting
    do_ack("R12 empty ack", 1'b0, 8'h00, 2);
    @(negedge clk);
    check("R12 int after", 32'(int_o), 0);
    check("R12 ieo after", 32'(ieo_o), 1);

    // R11 merged requests
    pulse_req(4'b0100);
    pulse_req(4'b0100);
    pulse_req(4'b0100);
    check("R11 int", 32'(int_o), 1);
    do_ack("R11 ack ch2", 1'b1, 8'hAC, 1);
    pulse_reti();
    check("R11 no repeat int", 32'(int_o), 0);
    check("R11 ieo free", 32'(ieo_o), 1);

    // R1 reset taken mid-operation
    pulse_req(4'b0001);
    check("R1 pre int", 32'(int_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset int", 32'(int_o), 0);
    check("R1 mid reset ieo", 32'(ieo_o), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pending gone", 32'(int_o), 0);
    pulse_req(4'b1000);
    do_ack("R1 base zero", 1'b1, 8'h06, 1);
    pulse_reti();

    summary();
  end

endmodule